// File: doc/BRIEF.md
# Sectioned Control Register Access Controller

This block sits behind a serial-bus slave front end and turns its byte stream into accesses to a 64-location control and clock register space. The front end reports the start of a transaction (with either a fresh word address or a request to reuse the current one), each data byte with its direction, and whether the transaction ended with a valid stop or was aborted. The block keeps an auto-incrementing word pointer, works out which of five register sections the pointer falls in, and acknowledges bytes only while the transaction stays inside the section it started in. The sections are two 8-byte alarm blocks, a 5-byte control block, an 8-byte clock block and a 1-byte status location.

Written bytes are gathered in a small staging buffer and are handed to the target registers as one parallel commit when a valid stop arrives. Commits to every section except status are gated by a two-level write enable that lives in the status byte. Clock-section bytes are also forwarded, as they arrive, to the time-counter shadow buffer. The section layout is 0x00-0x07 (alarm 0, code 0), 0x08-0x0F (alarm 1, code 1), 0x10-0x14 (control, code 2), 0x30-0x37 (clock, code 3) and 0x3F (status, code 4). All other addresses are undefined.

Top module: `sectreg_access`

## Requirements
- R1: After reset the word pointer (`rdAddr`) is 0x00, both write-enable levels (`welOut`, `rwelOut`) are 0 and `cmtValid` is 0.
- R2: Inside a section every byte is acknowledged in the cycle it is presented, a read byte drives `rdStb` with `rdAddr` equal to the pointer, and the pointer then advances by one (modulo 64).
- R3: A byte presented when the pointer has left the transaction's section is not acknowledged, the pointer stays put, and every later byte of that transaction is also refused.
- R4: A transaction that starts at an undefined address acknowledges no byte.
- R5: The status section accepts exactly one byte per transaction; a second byte is refused, and a status commit carries mask 0x01.
- R6: A committed status byte with bit 1 set and bit 2 clear sets `welOut` and clears `rwelOut`; bits 1 and 2 both set while `welOut` is already 1 sets both; any other committed status value clears both.
- R7: A write to a non-status section is committed only at a valid stop and only while both `welOut` and `rwelOut` are 1; otherwise no commit occurs.
- R8: A commit is a one-cycle `cmtValid` pulse in the cycle after the stop, with `cmtSect` holding the section code, `cmtMask` bit i set for each written offset i and the byte for offset i on `cmtData[8i+7:8i]`.
- R9: Each accepted clock-section write byte raises `shdWr` in its own cycle with `shdIdx` equal to its offset within the section and `shdData` equal to the byte.
- R10: Staged writes are discarded, with no commit, when the transaction is aborted or when it was ended by a refused byte.
- R11: A transaction started with `txnCurrent` set continues from the pointer left by the previous transaction (last address plus one).
- R12: A status write commits at a valid stop regardless of the write-enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | Start of a transaction (one-cycle pulse) |
| txnCurrent | input | 1 | With txnStart: keep the current pointer instead of txnAddr |
| txnAddr | input | 6 | Start word address |
| byteValid | input | 1 | A data byte is presented this cycle |
| byteWrite | input | 1 | Presented byte is a write (1) or a read (0) |
| wrData | input | 8 | Write byte |
| txnStop | input | 1 | Valid stop ends the transaction |
| txnAbort | input | 1 | Transaction aborted; staged writes dropped |
| byteAck | output | 1 | Presented byte accepted |
| rdStb | output | 1 | Read of the register at rdAddr this cycle |
| rdAddr | output | 6 | Current word pointer |
| shdWr | output | 1 | Clock-section byte to the shadow buffer |
| shdIdx | output | 3 | Offset of that byte within the clock section |
| shdData | output | 8 | Shadow write byte |
| cmtValid | output | 1 | Commit pulse |
| cmtSect | output | 3 | Section code of the commit |
| cmtMask | output | 8 | Written offsets of the commit |
| cmtData | output | 64 | Committed bytes, offset i at bits 8i+7:8i |
| welOut | output | 1 | First write-enable level |
| rwelOut | output | 1 | Second write-enable level |

## Verification
The bench builds the block with its default parameters: a 6-bit pointer, an 8-byte staging buffer and the section layout above, with the enable bits at positions 1 and 2. With that layout the 1-byte status location sits at the top of the space, so a second status byte reaches the pointer wrap from 0x3F to 0x00. The 5-byte control section ends inside the staging buffer, so the refusal at a section end is exercised both at a full-buffer boundary and part-way through the buffer. Undefined gaps both above the control section and below the clock section give two distinct refused start addresses.

// File: rtl/sectreg_pkg.sv
package sectreg_pkg;

  localparam int NUM_SECT = 5;

  typedef enum logic [2:0] {
    SEC_AL0  = 3'd0,
    SEC_AL1  = 3'd1,
    SEC_CTL  = 3'd2,
    SEC_CLK  = 3'd3,
    SEC_STS  = 3'd4,
    SEC_NONE = 3'd7
  } sect_e;

  // Strobes from the control module to the staging datapath
  typedef struct packed {
    logic  bufClr;
    logic  bufWr;
    logic  commit;
    sect_e sect;
  } ctlStb_t;

endpackage

// File: rtl/sectreg_ctrl.sv
module sectreg_ctrl
  import sectreg_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 3,
  parameter int AL0_BASE  = 0,
  parameter int AL1_BASE  = 8,
  parameter int CTL_BASE  = 16,
  parameter int CLK_BASE  = 48,
  parameter int STS_BASE  = 63,
  parameter int AL_SIZE   = 8,
  parameter int CTL_SIZE  = 5,
  parameter int CLK_SIZE  = 8,
  parameter int WEL_BIT   = 1,
  parameter int RWEL_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txnStart,
  input  logic              txnCurrent,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic              byteValid,
  input  logic              byteWrite,
  input  logic              txnStop,
  input  logic              txnAbort,
  input  logic [DATA_W-1:0] stsByte,
  output logic              byteAck,
  output logic              rdStb,
  output logic [ADDR_W-1:0] ptrOut,
  output logic [IDX_W-1:0]  bufIdx,
  output logic              welOut,
  output logic              rwelOut,
  output ctlStb_t           stb
);

  localparam int SECT_BASE [NUM_SECT] = '{AL0_BASE, AL1_BASE, CTL_BASE, CLK_BASE, STS_BASE};
  localparam int SECT_SIZE [NUM_SECT] = '{AL_SIZE, AL_SIZE, CTL_SIZE, CLK_SIZE, 1};

  function automatic sect_e sectOf(input logic [ADDR_W-1:0] a);
    sect_e s = SEC_NONE;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (int'(a) >= SECT_BASE[i] && int'(a) < SECT_BASE[i] + SECT_SIZE[i]) s = sect_e'(i);
    end
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] sectBase(input sect_e s);
    logic [ADDR_W-1:0] b = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      if (s == sect_e'(i)) b = ADDR_W'(SECT_BASE[i]);
    end
    return b;
  endfunction

  logic              active, halted, wrote;
  logic              wel, rwel;
  logic [ADDR_W-1:0] ptr;
  sect_e             txnSect;
  logic [ADDR_W-1:0] startPtr;
  logic              accept, commitNow, ctlFree;

  always_comb begin
    startPtr  = txnCurrent ? ptr : txnAddr;
    ctlFree   = !txnStart && !txnStop && !txnAbort;
    accept    = active && !halted && (txnSect != SEC_NONE) && (sectOf(ptr) == txnSect);
    byteAck   = byteValid && accept && ctlFree;
    rdStb     = byteAck && !byteWrite;
    commitNow = txnStop && !txnStart && !txnAbort && active && !halted && wrote &&
                ((txnSect == SEC_STS) || (wel && rwel));
    bufIdx     = IDX_W'(ptr - sectBase(txnSect));
    stb.bufClr = txnStart || txnAbort;
    stb.bufWr  = byteAck && byteWrite;
    stb.commit = commitNow;
    stb.sect   = txnSect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      halted  <= 1'b0;
      wrote   <= 1'b0;
      ptr     <= '0;
      txnSect <= SEC_NONE;
      wel     <= 1'b0;
      rwel    <= 1'b0;
    end else if (txnAbort) begin
      active <= 1'b0;
    end else if (txnStart) begin
      active  <= 1'b1;
      halted  <= 1'b0;
      wrote   <= 1'b0;
      ptr     <= startPtr;
      txnSect <= sectOf(startPtr);
    end else if (txnStop) begin
      active <= 1'b0;
      if (commitNow && txnSect == SEC_STS) begin
        if (stsByte[WEL_BIT] && !stsByte[RWEL_BIT]) begin
          wel  <= 1'b1;
          rwel <= 1'b0;
        end else if (stsByte[WEL_BIT] && stsByte[RWEL_BIT] && wel) begin
          wel  <= 1'b1;
          rwel <= 1'b1;
        end else begin
          wel  <= 1'b0;
          rwel <= 1'b0;
        end
      end
    end else if (byteValid && active) begin
      if (byteAck) begin
        ptr   <= ptr + 1'b1;
        wrote <= wrote | byteWrite;
      end else begin
        halted <= 1'b1;
      end
    end
  end

  assign ptrOut  = ptr;
  assign welOut  = wel;
  assign rwelOut = rwel;

endmodule

// File: rtl/sectreg_dpath.sv
module sectreg_dpath
  import sectreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStb_t                 stb,
  input  logic [IDX_W-1:0]        bufIdx,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       stsByte,
  output logic                    shdWr,
  output logic [IDX_W-1:0]        shdIdx,
  output logic [DATA_W-1:0]       shdData,
  output logic                    cmtValid,
  output sect_e                   cmtSect,
  output logic [DEPTH-1:0]        cmtMask,
  output logic [DEPTH*DATA_W-1:0] cmtData
);

  logic [DATA_W-1:0]       bufData [DEPTH];
  logic [DEPTH-1:0]        bufMask;
  logic [DEPTH*DATA_W-1:0] bufFlat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign bufFlat[g*DATA_W +: DATA_W] = bufData[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.bufClr) begin
      bufMask <= '0;
      for (int i = 0; i < DEPTH; i++) bufData[i] <= '0;
    end else if (stb.bufWr) begin
      bufData[bufIdx] <= wrData;
      bufMask[bufIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmtValid <= 1'b0;
      cmtSect  <= SEC_NONE;
      cmtMask  <= '0;
      cmtData  <= '0;
    end else begin
      cmtValid <= stb.commit;
      if (stb.commit) begin
        cmtSect <= stb.sect;
        cmtMask <= bufMask;
        cmtData <= bufFlat;
      end
    end
  end

  assign stsByte = bufData[0];
  assign shdWr   = stb.bufWr && (stb.sect == SEC_CLK);
  assign shdIdx  = bufIdx;
  assign shdData = wrData;

endmodule

// File: rtl/sectreg_access.sv
module sectreg_access
  import sectreg_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 8,
  parameter int AL0_BASE  = 0,
  parameter int AL1_BASE  = 8,
  parameter int CTL_BASE  = 16,
  parameter int CLK_BASE  = 48,
  parameter int STS_BASE  = 63,
  parameter int AL_SIZE   = 8,
  parameter int CTL_SIZE  = 5,
  parameter int CLK_SIZE  = 8,
  parameter int WEL_BIT   = 1,
  parameter int RWEL_BIT  = 2,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        txnStart,
  input  logic                        txnCurrent,
  input  logic [ADDR_W-1:0]           txnAddr,
  input  logic                        byteValid,
  input  logic                        byteWrite,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        txnStop,
  input  logic                        txnAbort,
  output logic                        byteAck,
  output logic                        rdStb,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic                        shdWr,
  output logic [IDX_W-1:0]            shdIdx,
  output logic [DATA_W-1:0]           shdData,
  output logic                        cmtValid,
  output logic [2:0]                  cmtSect,
  output logic [BUF_DEPTH-1:0]        cmtMask,
  output logic [BUF_DEPTH*DATA_W-1:0] cmtData,
  output logic                        welOut,
  output logic                        rwelOut
);

  ctlStb_t           stb;
  logic [IDX_W-1:0]  bufIdx;
  logic [DATA_W-1:0] stsByte;
  sect_e             cmtSectE;

  sectreg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .AL0_BASE(AL0_BASE), .AL1_BASE(AL1_BASE), .CTL_BASE(CTL_BASE),
    .CLK_BASE(CLK_BASE), .STS_BASE(STS_BASE), .AL_SIZE(AL_SIZE),
    .CTL_SIZE(CTL_SIZE), .CLK_SIZE(CLK_SIZE),
    .WEL_BIT(WEL_BIT), .RWEL_BIT(RWEL_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnCurrent(txnCurrent),
    .txnAddr(txnAddr), .byteValid(byteValid), .byteWrite(byteWrite),
    .txnStop(txnStop), .txnAbort(txnAbort), .stsByte(stsByte),
    .byteAck(byteAck), .rdStb(rdStb), .ptrOut(rdAddr), .bufIdx(bufIdx),
    .welOut(welOut), .rwelOut(rwelOut), .stb(stb)
  );

  sectreg_dpath #(
    .DATA_W(DATA_W), .DEPTH(BUF_DEPTH), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bufIdx(bufIdx), .wrData(wrData),
    .stsByte(stsByte), .shdWr(shdWr), .shdIdx(shdIdx), .shdData(shdData),
    .cmtValid(cmtValid), .cmtSect(cmtSectE), .cmtMask(cmtMask), .cmtData(cmtData)
  );

  assign cmtSect = cmtSectE;

endmodule

// File: rtl/sectreg_access_chk.sv
module sectreg_access_chk #(
  parameter int ADDR_W    = 6,
  parameter int BUF_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 txnStop,
  input logic                 byteWrite,
  input logic                 byteAck,
  input logic [ADDR_W-1:0]    rdAddr,
  input logic                 shdWr,
  input logic                 cmtValid,
  input logic [2:0]           cmtSect,
  input logic [BUF_DEPTH-1:0] cmtMask,
  input logic                 welOut,
  input logic                 rwelOut
);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (byteAck && !byteWrite) |=> (rdAddr == $past(rdAddr) + 1'b1)); // R2

  AST_STS_ONE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && cmtSect == 3'd4) |-> (cmtMask == BUF_DEPTH'(1))); // R5

  AST_RWEL_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rwelOut) |-> $past(welOut)); // R6

  AST_CMT_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |-> $past(txnStop)); // R7

  AST_CMT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (cmtValid && cmtSect != 3'd4) |-> (welOut && rwelOut)); // R7

  AST_CMT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |=> !cmtValid); // R8

  AST_CMT_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |-> (cmtMask != '0)); // R8

  AST_SHD_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    shdWr |-> (byteAck && byteWrite)); // R9

endmodule

bind sectreg_access sectreg_access_chk #(
  .ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)
) u_chk (.*);

// File: tb/sectreg_access_tb.sv
module sectreg_access_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txnStart = 1'b0, txnCurrent = 1'b0;
  logic [5:0]  txnAddr = '0;
  logic        byteValid = 1'b0, byteWrite = 1'b0;
  logic [7:0]  wrData = '0;
  logic        txnStop = 1'b0, txnAbort = 1'b0;
  logic        byteAck, rdStb, shdWr, cmtValid, welOut, rwelOut;
  logic [5:0]  rdAddr;
  logic [2:0]  shdIdx, cmtSect;
  logic [7:0]  shdData, cmtMask;
  logic [63:0] cmtData;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sectreg_access u_dut (
    .clk(clk), .rstN(rstN), .txnStart(txnStart), .txnCurrent(txnCurrent),
    .txnAddr(txnAddr), .byteValid(byteValid), .byteWrite(byteWrite),
    .wrData(wrData), .txnStop(txnStop), .txnAbort(txnAbort),
    .byteAck(byteAck), .rdStb(rdStb), .rdAddr(rdAddr), .shdWr(shdWr),
    .shdIdx(shdIdx), .shdData(shdData), .cmtValid(cmtValid),
    .cmtSect(cmtSect), .cmtMask(cmtMask), .cmtData(cmtData),
    .welOut(welOut), .rwelOut(rwelOut)
  );

  typedef struct packed {
    logic [5:0] addr;
    logic [3:0] nBytes;
    logic [3:0] acks;
    logic [5:0] endPtr;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{6'h00, 4'd8,  4'd8, 6'h08},  // R2 full alarm 0
    '{6'h00, 4'd10, 4'd8, 6'h08},  // R3 run past alarm 0
    '{6'h05, 4'd5,  4'd3, 6'h08},  // R3 mid-section start
    '{6'h08, 4'd9,  4'd8, 6'h10},  // R3 alarm 1
    '{6'h10, 4'd7,  4'd5, 6'h15},  // R3 control ends inside buffer
    '{6'h12, 4'd2,  4'd2, 6'h14},  // R2 control partial
    '{6'h30, 4'd9,  4'd8, 6'h38},  // R3 clock
    '{6'h3F, 4'd3,  4'd1, 6'h00},  // R5 status single byte, pointer wraps
    '{6'h20, 4'd2,  4'd0, 6'h20},  // R4 undefined gap
    '{6'h15, 4'd1,  4'd0, 6'h15}   // R4 just past control
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStart(input logic [5:0] a, input logic cur);
    txnAddr = a; txnCurrent = cur; txnStart = 1'b1;
    @(negedge clk);
    txnStart = 1'b0; txnCurrent = 1'b0;
  endtask

  task automatic doByte(input logic wr, input logic [7:0] d, output logic ack,
                        output logic sw, output logic [2:0] si, output logic [7:0] sd);
    byteValid = 1'b1; byteWrite = wr; wrData = d;
    #1;
    ack = byteAck; sw = shdWr; si = shdIdx; sd = shdData;
    @(negedge clk);
    byteValid = 1'b0; byteWrite = 1'b0;
  endtask

  task automatic doStop();
    txnStop = 1'b1;
    @(negedge clk);
    txnStop = 1'b0;
  endtask

  task automatic doAbort();
    txnAbort = 1'b1;
    @(negedge clk);
    txnAbort = 1'b0;
  endtask

  task automatic statusWrite(input logic [7:0] d);
    logic a, s; logic [2:0] i; logic [7:0] sd;
    doStart(6'h3F, 1'b0);
    doByte(1'b1, d, a, s, i, sd);
    doStop();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic a, s; logic [2:0] si; logic [7:0] sd;
    int n;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pointer", 64'(rdAddr), 64'h00);
    check("R1 wel", 64'(welOut), 64'h0);
    check("R1 rwel", 64'(rwelOut), 64'h0);
    check("R1 cmtValid", 64'(cmtValid), 64'h0);

    // read vectors: R2 R3 R4 R5
    for (int v = 0; v < 10; v++) begin
      doStart(VECS[v].addr, 1'b0);
      n = 0;
      for (int k = 0; k < int'(VECS[v].nBytes); k++) begin
        doByte(1'b0, 8'h00, a, s, si, sd);
        n += int'(a);
      end
      check("R2/R3/R4/R5 ack count", 64'(n), 64'(VECS[v].acks));
      check("R2/R3 end pointer", 64'(rdAddr), 64'(VECS[v].endPtr));
      doStop();
    end

    // R7: alarm write without enables is dropped
    doStart(6'h00, 1'b0);
    doByte(1'b1, 8'h11, a, s, si, sd);
    doStop();
    check("R7 no commit without enables", 64'(cmtValid), 64'h0);

    // R12 R6: first enable level
    doStart(6'h3F, 1'b0);
    doByte(1'b1, 8'h02, a, s, si, sd);
    doStop();
    check("R12 status commit", 64'(cmtValid), 64'h1);
    check("R12 status sect", 64'(cmtSect), 64'h4);
    check("R5 status mask", 64'(cmtMask), 64'h01);
    check("R12 status data", 64'(cmtData[7:0]), 64'h02);
    check("R6 wel set", 64'(welOut), 64'h1);
    check("R6 rwel clear", 64'(rwelOut), 64'h0);

    statusWrite(8'h06);
    check("R6 wel both", 64'(welOut), 64'h1);
    check("R6 rwel both", 64'(rwelOut), 64'h1);

    // R8: alarm 1 commit layout
    doStart(6'h0A, 1'b0);
    doByte(1'b1, 8'hA5, a, s, si, sd);
    doByte(1'b1, 8'h5A, a, s, si, sd);
    doStop();
    check("R7 commit with enables", 64'(cmtValid), 64'h1);
    check("R8 sect", 64'(cmtSect), 64'h1);
    check("R8 mask", 64'(cmtMask), 64'h0C);
    check("R8 data", 64'(cmtData[31:16]), 64'h5AA5);
    @(negedge clk);
    check("R8 one-cycle pulse", 64'(cmtValid), 64'h0);

    // R9: clock shadow path
    doStart(6'h31, 1'b0);
    doByte(1'b1, 8'h77, a, s, si, sd);
    check("R9 shdWr", 64'(s), 64'h1);
    check("R9 shdIdx", 64'(si), 64'h1);
    check("R9 shdData", 64'(sd), 64'h77);
    doStop();
    check("R8 clock sect", 64'(cmtSect), 64'h3);
    check("R8 clock mask", 64'(cmtMask), 64'h02);

    // R10: abort discards
    doStart(6'h00, 1'b0);
    doByte(1'b1, 8'h33, a, s, si, sd);
    check("R9 no shadow outside clock", 64'(s), 64'h0);
    doAbort();
    doStop();
    check("R10 abort drops commit", 64'(cmtValid), 64'h0);

    // R3 R10: overflow ends the write
    doStart(6'h13, 1'b0);
    doByte(1'b1, 8'h01, a, s, si, sd);
    doByte(1'b1, 8'h02, a, s, si, sd);
    doByte(1'b1, 8'h03, a, s, si, sd);
    check("R3 past control refused", 64'(a), 64'h0);
    doStop();
    check("R10 overflow drops commit", 64'(cmtValid), 64'h0);

    // R11: current-address continuation
    doStart(6'h10, 1'b0);
    doByte(1'b0, 8'h00, a, s, si, sd);
    doByte(1'b0, 8'h00, a, s, si, sd);
    doStop();
    doStart(6'h00, 1'b1);
    check("R11 pointer kept", 64'(rdAddr), 64'h12);
    doByte(1'b0, 8'h00, a, s, si, sd);
    check("R11 continued read acked", 64'(a), 64'h1);
    doStop();

    // R6: out-of-order patterns clear both levels
    statusWrite(8'h04);
    check("R6 clear wel", 64'(welOut), 64'h0);
    check("R6 clear rwel", 64'(rwelOut), 64'h0);
    statusWrite(8'h06);
    check("R6 no skip wel", 64'(welOut), 64'h0);
    check("R6 no skip rwel", 64'(rwelOut), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule